// File: doc/BRIEF.md
# Flash Status Register and Protection Unit

This block is the device-side status register of a serial NOR flash. An SPI target front end hands it command bytes one at a time, together with the chip-select level. From these bytes it handles the write-enable latch, reads and writes the status register, and keeps returning the status byte for as long as a status read transfer stays open. It does not contain the memory array or the bit shifter.

The block also decides whether a program or erase request may start. Such a request carries a byte address. It is granted only when three conditions hold: the write-enable latch is set, no internal operation is running, and the address lies outside the upper region that the block-protect field covers. A granted request sets the busy flag. An external timer later sends a done pulse, which ends the operation. The array size is a power of two, 2^ADDR_W bytes, and ADDR_W must be at least 6.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte is 0x00, `txActive` is 0, and both `opGrant` and `opDeny` are 0.
- R2: When no operation is running, opcode 0x06 sets status bit 1 (write-enable latch) and opcode 0x04 clears it. Each takes effect on the cycle its opcode byte is received.
- R3: After opcode 0x05, `txActive` is 1 and `txByte` shows the live status byte on every following byte. This lasts until `csN` goes high, and `txActive` is 0 from the cycle after that. When `txActive` is 0, `txByte` is 0x00.
- R4: Opcode 0x01 followed by a data byte works as follows when the latch is 1: data bit 7 goes to status bit 7 (status write-protect flag), data bits 4:2 go to status bits 4:2 (protect level), and the latch is cleared. When the latch is 0, the data byte changes nothing. Status bits 6:5 always read 0, and bits 1:0 are never taken from the data byte.
- R5: A request on `opReq` is granted when the latch is 1, status bit 0 (write in progress) is 0, and the address is not protected. `opGrant` pulses for one cycle, and status bit 0 reads 1 in that same cycle.
- R6: A request made while the latch is 0 gives a one-cycle `opDeny` pulse and leaves the status byte unchanged.
- R7: Protect level k in 1..6 protects the addresses at or above 2^ADDR_W − 2^ADDR_W/2^(7−k). Level 0 protects nothing and level 7 protects every address. A request to a protected address is denied.
- R8: A `doneIn` pulse while status bit 0 is 1 clears both status bit 0 and status bit 1.
- R9: While status bit 0 is 1, the following are ignored: opcodes 0x06 and 0x04, status writes, and requests (which are denied). A status read still works.
- R10: Only the first byte after `csN` falls is decoded as an opcode. Later bytes of an unknown command have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low; high ends the command |
| rxValid | input | 1 | A received byte is present on `rxByte` |
| rxByte | input | 8 | Received command or data byte |
| opReq | input | 1 | Program or erase request strobe |
| opAddr | input | ADDR_W | Byte address of the request |
| doneIn | input | 1 | Pulse from the external timer: operation finished |
| opGrant | output | 1 | Request accepted (one-cycle pulse) |
| opDeny | output | 1 | Request refused (one-cycle pulse) |
| txActive | output | 1 | Status read transfer is open |
| txByte | output | 8 | Byte to shift out |

## Verification
The bench builds the block with ADDR_W = 12, which gives a 4 KiB array. With this size the edge of each protected region is a small, readable address: 0xFC0 for one sixty-fourth and 0x800 for one half. This lets the bench test the address on each side of the boundary for every protect level. The small width still exercises every level, including the two end cases where nothing or everything is protected.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  localparam int BP_W      = 3;
  localparam int MAX_SHARE = (1 << BP_W) - 2;  // deepest partial region: 1/2^6

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic writeSr;
    logic grant;
    logic deny;
    logic finish;
  } srStrobe_t;

  typedef enum logic [1:0] {
    ST_OPCODE,
    ST_STATUS,
    ST_SRDATA,
    ST_DRAIN
  } cmdState_t;
endpackage

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       opReq,
  input  logic       doneIn,
  input  logic       welQ,
  input  logic       wipQ,
  input  logic       addrLocked,
  output srStrobe_t  strb,
  output logic       txActive
);
  cmdState_t stateQ;
  logic byteIn;
  logic opcodeByte;
  logic idle;

  assign byteIn     = rxValid && !csN;
  assign opcodeByte = byteIn && (stateQ == ST_OPCODE);
  assign idle       = !wipQ;

  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      stateQ <= ST_OPCODE;
    end else if (byteIn) begin
      unique case (stateQ)
        ST_OPCODE: begin
          if (rxByte == OP_RDSR)      stateQ <= ST_STATUS;
          else if (rxByte == OP_WRSR) stateQ <= ST_SRDATA;
          else                        stateQ <= ST_DRAIN;
        end
        ST_SRDATA: stateQ <= ST_DRAIN;
        ST_STATUS: stateQ <= ST_STATUS;
        default:   stateQ <= ST_DRAIN;
      endcase
    end
  end

  always_comb begin
    strb.setWel  = opcodeByte && (rxByte == OP_WREN) && idle;
    strb.clrWel  = opcodeByte && (rxByte == OP_WRDI) && idle;
    strb.writeSr = byteIn && (stateQ == ST_SRDATA) && welQ && idle;
    strb.grant   = opReq && welQ && idle && !addrLocked;
    strb.deny    = opReq && !(welQ && idle && !addrLocked);
    strb.finish  = doneIn && wipQ;
  end

  assign txActive = (stateQ == ST_STATUS);
endmodule

// File: rtl/flash_sr_dp.sv
module flash_sr_dp
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strb,
  input  logic              srwpIn,
  input  logic [BP_W-1:0]   bpIn,
  input  logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        statusQ,
  output logic              addrLocked,
  output logic              opGrant,
  output logic              opDeny
);
  localparam logic [BP_W-1:0] BP_ALL = '1;

  logic            wipQ, welQ, srwpQ;
  logic [BP_W-1:0] bpQ;
  logic [MAX_SHARE:1] topOnes;

  for (genvar n = 1; n <= MAX_SHARE; n++) begin : g_top
    assign topOnes[n] = &opAddr[ADDR_W-1 -: n];
  end

  always_comb begin
    if (bpQ == '0)          addrLocked = 1'b0;
    else if (bpQ == BP_ALL) addrLocked = 1'b1;
    else                    addrLocked = topOnes[BP_ALL - bpQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wipQ    <= 1'b0;
      welQ    <= 1'b0;
      srwpQ   <= 1'b0;
      bpQ     <= '0;
      opGrant <= 1'b0;
      opDeny  <= 1'b0;
    end else begin
      opGrant <= strb.grant;
      opDeny  <= strb.deny;
      if (strb.grant)       wipQ <= 1'b1;
      else if (strb.finish) wipQ <= 1'b0;
      if (strb.setWel)                                     welQ <= 1'b1;
      else if (strb.clrWel || strb.finish || strb.writeSr) welQ <= 1'b0;
      if (strb.writeSr) begin
        srwpQ <= srwpIn;
        bpQ   <= bpIn;
      end
    end
  end

  assign statusQ = {srwpQ, 2'b00, bpQ, welQ, wipQ};
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              opReq,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              doneIn,
  output logic              opGrant,
  output logic              opDeny,
  output logic              txActive,
  output logic [7:0]        txByte
);
  srStrobe_t  strb;
  logic [7:0] statusQ;
  logic       addrLocked;

  flash_sr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .opReq(opReq), .doneIn(doneIn), .welQ(statusQ[1]), .wipQ(statusQ[0]),
    .addrLocked(addrLocked), .strb(strb), .txActive(txActive)
  );

  flash_sr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srwpIn(rxByte[7]), .bpIn(rxByte[4:2]),
    .opAddr(opAddr), .statusQ(statusQ), .addrLocked(addrLocked),
    .opGrant(opGrant), .opDeny(opDeny)
  );

  assign txByte = txActive ? statusQ : 8'h00;
endmodule

// File: rtl/flash_status_unit_chk.sv
module flash_status_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       opReq,
  input logic       doneIn,
  input logic       opGrant,
  input logic       opDeny,
  input logic       txActive,
  input logic [7:0] status
);
  p_grant_deny_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(opGrant && opDeny));

  p_grant_sets_wip_r5: assert property (@(posedge clk) disable iff (!rstN)
    opGrant |-> status[0]);

  p_no_grant_unlatched_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !status[1]) |=> (opDeny && !opGrant));

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && status[0]) |=> (status[1:0] == 2'b00));

  p_busy_denies_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && status[0]) |=> opDeny);

  p_tx_closes_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !txActive);
endmodule

bind flash_status_unit flash_status_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .opReq(opReq), .doneIn(doneIn),
  .opGrant(opGrant), .opDeny(opDeny), .txActive(txActive), .status(statusQ)
);

// File: tb/flash_status_unit_bench.sv
module flash_status_unit_bench;
  localparam int AW = 12;
  localparam int NVEC = 12;
  // {protect level, expect grant, address}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 12'hFFF}, {3'd1, 1'b1, 12'hFBF}, {3'd1, 1'b0, 12'hFC0},
    {3'd2, 1'b1, 12'hF7F}, {3'd2, 1'b0, 12'hF80}, {3'd3, 1'b1, 12'hEFF},
    {3'd3, 1'b0, 12'hF00}, {3'd4, 1'b0, 12'hE00}, {3'd5, 1'b1, 12'hBFF},
    {3'd6, 1'b1, 12'h7FF}, {3'd6, 1'b0, 12'h800}, {3'd7, 1'b0, 12'h000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0, csN = 1'b1, rxValid = 1'b0, opReq = 1'b0, doneIn = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic [AW-1:0] opAddr = '0;
  logic opGrant, opDeny, txActive;
  logic [7:0] txByte;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_status_unit #(.ADDR_W(AW)) u_flash_status_unit (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .opReq(opReq), .opAddr(opAddr), .doneIn(doneIn), .opGrant(opGrant),
    .opDeny(opDeny), .txActive(txActive), .txByte(txByte)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic csLow();
    csN = 1'b0; @(negedge clk);
  endtask

  task automatic csHigh();
    csN = 1'b1; @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    csLow(); sendByte(op); csHigh();
  endtask

  task automatic cmd2(input logic [7:0] op, input logic [7:0] d);
    csLow(); sendByte(op); sendByte(d); csHigh();
  endtask

  task automatic readStatus(output logic [7:0] s);
    csLow(); sendByte(8'h05); s = txByte; csHigh();
  endtask

  task automatic request(input logic [AW-1:0] a, output logic g, output logic d);
    opReq = 1'b1; opAddr = a;
    @(negedge clk);
    opReq = 1'b0;
    g = opGrant; d = opDeny;
  endtask

  task automatic pulseDone();
    doneIn = 1'b1; @(negedge clk); doneIn = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic g, d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txActive", {15'd0, txActive}, 16'd0);
    chk("R1 grant/deny", {14'd0, opGrant, opDeny}, 16'd0);
    readStatus(s);
    chk("R1 status", {8'd0, s}, 16'h0000);

    // R2 latch set and clear
    cmd1(8'h06); readStatus(s);
    chk("R2 set latch", {8'd0, s}, 16'h0002);
    cmd1(8'h04); readStatus(s);
    chk("R2 clear latch", {8'd0, s}, 16'h0000);

    // R4 status write gated by the latch, bits 6:5 and 1:0 not written
    cmd2(8'h01, 8'hFC); readStatus(s);
    chk("R4 write without latch", {8'd0, s}, 16'h0000);
    cmd1(8'h06); cmd2(8'h01, 8'hFF); readStatus(s);
    chk("R4 write with latch", {8'd0, s}, 16'h009C);
    cmd1(8'h06); cmd2(8'h01, 8'h00); readStatus(s);
    chk("R4 restore", {8'd0, s}, 16'h0000);

    // R6 request without the latch
    request(12'h100, g, d);
    chk("R6 deny unlatched", {14'd0, g, d}, 16'h0001);
    readStatus(s);
    chk("R6 status unchanged", {8'd0, s}, 16'h0000);

    // R5 grant, R9 busy, R8 done
    cmd1(8'h06);
    request(12'h100, g, d);
    chk("R5 grant", {14'd0, g, d}, 16'h0002);
    readStatus(s);
    chk("R5 busy set", {8'd0, s}, 16'h0003);
    cmd1(8'h04); readStatus(s);
    chk("R9 clear ignored while busy", {8'd0, s}, 16'h0003);
    cmd1(8'h06); cmd2(8'h01, 8'h1C); readStatus(s);
    chk("R9 status write ignored while busy", {8'd0, s}, 16'h0003);
    request(12'h200, g, d);
    chk("R9 deny while busy", {14'd0, g, d}, 16'h0001);
    pulseDone(); readStatus(s);
    chk("R8 done clears", {8'd0, s}, 16'h0000);

    // R3 repeated status bytes, then closing
    cmd1(8'h06);
    csLow(); sendByte(8'h05);
    for (int i = 0; i < 3; i++) begin
      chk("R3 tx open", {7'd0, txActive, txByte}, 16'h0102);
      sendByte(8'hA5);
    end
    csHigh();
    chk("R3 tx closed", {7'd0, txActive, txByte}, 16'h0000);
    cmd1(8'h04);

    // R10 only first byte decoded
    cmd2(8'h9F, 8'h06); readStatus(s);
    chk("R10 second byte ignored", {8'd0, s}, 16'h0000);

    // R7 protection table
    for (int i = 0; i < NVEC; i++) begin
      cmd1(8'h06);
      cmd2(8'h01, {3'b000, VEC[i][15:13], 2'b00});
      cmd1(8'h06);
      request(VEC[i][11:0], g, d);
      chk($sformatf("R7 level %0d addr %h", VEC[i][15:13], VEC[i][11:0]),
          {14'd0, g, d}, VEC[i][12] ? 16'h0002 : 16'h0001);
      if (g) pulseDone();
    end
    cmd1(8'h06); cmd2(8'h01, 8'h00);

    finished = 1;
    summary();
    $finish;
  end
endmodule